// File: doc/BRIEF.md
# Two-Tone FSK Audio Modulator with Flag Framing

This block turns a stream of bytes into unsigned 8-bit audio samples for a 1200 bit/s link. The link uses two tones: mark at 1200 Hz and space at 2200 Hz. A numerically controlled oscillator produces each sample. It has a 9-bit phase accumulator and a stored quarter wave that is mirrored to build the full period. Bits leave least significant bit first in NRZI form: a 1 keeps the current tone and a 0 swaps it. Within data bytes, a zero is inserted after five ones in a row.

A frame begins when `tx_req` is pulsed. The block then sends a number of flag bytes (0x7E) given on `preamble_len`. After that it takes bytes from the input handshake. When the input runs dry, it sends flag bytes and counts them against `trailer_len`. It stops when the input is empty and the trailer count is zero. Each byte carries an escape bit. An unescaped 0x7E or 0x7F is sent as-is, with no zero insertion. An escaped byte is always sent as data, with zero insertion.

A pulse of `sample_tick` marks each audio sample period. The block answers one clock later with `sample` and a one-cycle `sample_valid`.

Top module: `afsk_modulator`

## Requirements
- R1: After reset, `busy`, `sample_valid` and `in_ready` are 0 and `sample` is 128. The phase accumulator is 0 and the tone is mark. While idle, ticks produce no samples and leave the phase unchanged.
- R2: A sample for phase p (0..511) is computed as follows. Let h = p mod 256. If h >= 128, replace h with 255-h. Then v = 128 + (127*h*(256-h) + 8192) div 16384. The sample is 255-v when p >= 256, and v otherwise.
- R3: Each sample tick while busy advances the phase by 64 (mark) or 117 (space), modulo 512. The sample for the new phase appears with `sample_valid` high for exactly one cycle, in the cycle after the tick.
- R4: Every bit lasts 8 ticks. Bits of a byte go out least significant bit first.
- R5: A frame starts on the mark tone. For each bit, a 1 keeps the tone and a 0 switches it, starting from the first sample of that bit.
- R6: In a byte with stuffing enabled, five consecutive 1 bits are followed by an inserted 8-tick zero, which switches the tone. The count of ones restarts at every byte boundary, so a run that ends a byte causes no insertion.
- R7: An input byte of 0x7E or 0x7F with escape bit 0 is sent with stuffing disabled. Any byte with escape bit 1, and any other value, is sent with stuffing enabled. Generated flags are never stuffed.
- R8: After a request from idle, exactly `preamble_len` flag bytes are sent before the first input byte is accepted.
- R9: Each time a byte starts and no input byte is valid, a flag byte is sent and the trailer count drops by one. When a byte would start with no valid input and the trailer count at zero, `busy` falls and that tick produces no sample.
- R10: A `tx_req` while busy reloads the trailer count from `trailer_len`. It does not restart the preamble.
- R11: `in_ready` is high only in the tick cycle where a byte starts, the preamble is finished and `in_valid` is high. That byte is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle pulse per audio sample period |
| tx_req | input | 1 | Start a frame, or reload the trailer if busy |
| preamble_len | input | 8 | Number of leading flag bytes |
| trailer_len | input | 8 | Number of trailing flag bytes |
| in_data | input | 8 | Byte to send |
| in_esc | input | 1 | Send this byte as data even if it is 0x7E/0x7F |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte taken in this cycle |
| sample | output | 8 | Unsigned audio sample |
| sample_valid | output | 1 | `sample` updated |
| busy | output | 1 | Frame in progress |

## Verification
A new sample is due one clock after the tick that produced it. The bench therefore compares `sample` at the falling edge after each tick, against a queue of values that a bit-level model of the frame filled in advance. `in_ready` is combinational in the tick cycle, so the bench latches it at the rising edge and consumes the byte at the next falling edge. `busy` drops one clock after the tick that finds nothing left to send. The bench waits for that edge and then checks that the expected queue and the input queue are both empty.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'h7F;

  // Rounded phase step per sample for one tone.
  function automatic int tone_step(int freq_hz, int rate_hz, int wave_len);
    return (wave_len * freq_hz + rate_hz / 2) / rate_hz;
  endfunction

  // Level of the rising quarter wave at index idx out of qlen entries.
  function automatic logic [7:0] quarter_level(int idx, int qlen);
    int num;
    num = 127 * idx * (2 * qlen - idx) + (qlen * qlen) / 2;
    return 8'(128 + num / (qlen * qlen));
  endfunction

  // Bytes that look like framing go out raw unless marked as data.
  function automatic logic is_stuffable(logic [7:0] b, logic esc);
    return esc || !((b == FLAG_BYTE) || (b == ABORT_BYTE));
  endfunction

endpackage

// File: rtl/afsk_dds.sv
module afsk_dds #(
  parameter int PHASE_W    = 9,
  parameter int MARK_STEP  = 64,
  parameter int SPACE_STEP = 117
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               space_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [7:0]         sample_o,
  output logic               valid_o
);
  localparam int QW   = PHASE_W - 2;
  localparam int QLEN = 2 ** QW;

  logic [7:0] qtab [QLEN];
  for (genvar g = 0; g < QLEN; g++) begin : g_qtab
    assign qtab[g] = afsk_pkg::quarter_level(g, QLEN);
  end

  logic [PHASE_W-1:0] phase_q, phase_nx;
  logic [PHASE_W-2:0] half_idx;
  logic [QW-1:0]      q_idx;
  logic [7:0]         q_val, samp_nx;

  always_comb begin
    phase_nx = phase_q + (space_i ? PHASE_W'(SPACE_STEP) : PHASE_W'(MARK_STEP));
    half_idx = phase_nx[PHASE_W-2:0];
    q_idx    = half_idx[PHASE_W-2] ? ~half_idx[QW-1:0] : half_idx[QW-1:0];
    q_val    = qtab[q_idx];
    samp_nx  = phase_nx[PHASE_W-1] ? ~q_val : q_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= '0;
      sample_o <= afsk_pkg::quarter_level(0, QLEN);
      valid_o  <= 1'b0;
    end else begin
      valid_o <= step_i;
      if (step_i) begin
        phase_q  <= phase_nx;
        sample_o <= samp_nx;
      end
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/afsk_framer.sv
module afsk_framer #(
  parameter int SAMPLES_PER_BIT = 8,
  parameter int CNT_W           = 8,
  parameter int STUFF_RUN       = 5,
  parameter int ONES_W          = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             tx_req,
  input  logic [CNT_W-1:0] preamble_len,
  input  logic [CNT_W-1:0] trailer_len,
  input  logic [7:0]       in_data,
  input  logic             in_esc,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             busy,
  output logic             emit_o,
  output logic             space_o,
  output logic             stuff_ins_o,
  output logic             stuff_en_o,
  output logic [ONES_W-1:0] ones_o
);
  localparam int SC_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam logic [3:0] BYTE_DONE = 4'd8;

  logic              busy_q, space_q, stuff_q;
  logic [CNT_W-1:0]  pre_q, trl_q;
  logic [SC_W-1:0]   samp_q;
  logic [3:0]        idx_q;
  logic [7:0]        cur_q;
  logic [ONES_W-1:0] ones_q;

  logic tick_act, bit_start, byte_start, stop_now, take;
  logic [7:0]        byte_x;
  logic              stuff_x, insert, bit_val, flip, space_now;
  logic [ONES_W-1:0] ones_x;
  logic [3:0]        idx_x;

  always_comb begin
    tick_act   = sample_tick && busy_q;
    bit_start  = tick_act && (samp_q == '0);
    byte_start = bit_start && (idx_q == BYTE_DONE);
    stop_now   = byte_start && !in_valid && (trl_q == '0);
    take       = byte_start && (pre_q == '0) && in_valid;
    byte_x     = byte_start ? (take ? in_data : afsk_pkg::FLAG_BYTE) : cur_q;
    stuff_x    = byte_start ? (take && afsk_pkg::is_stuffable(in_data, in_esc)) : stuff_q;
    ones_x     = byte_start ? '0 : ones_q;
    idx_x      = byte_start ? 4'd0 : idx_q;
    insert     = stuff_x && (ones_x >= ONES_W'(STUFF_RUN));
    bit_val    = byte_x[idx_x[2:0]];
    flip       = insert || !bit_val;
    space_now  = (bit_start && !stop_now && flip) ? !space_q : space_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      space_q <= 1'b0;
      stuff_q <= 1'b0;
      pre_q   <= '0;
      trl_q   <= '0;
      samp_q  <= '0;
      idx_q   <= BYTE_DONE;
      cur_q   <= '0;
      ones_q  <= '0;
    end else if (tx_req && !busy_q) begin
      busy_q  <= 1'b1;
      pre_q   <= preamble_len;
      trl_q   <= trailer_len;
      samp_q  <= '0;
      idx_q   <= BYTE_DONE;
      ones_q  <= '0;
      space_q <= 1'b0;
      stuff_q <= 1'b0;
    end else begin
      if (tx_req) trl_q <= trailer_len;
      if (stop_now) begin
        busy_q <= 1'b0;
      end else if (tick_act) begin
        samp_q <= bit_start ? SC_W'(SAMPLES_PER_BIT - 1) : samp_q - 1'b1;
        if (bit_start) begin
          space_q <= space_now;
          cur_q   <= byte_x;
          stuff_q <= stuff_x;
          idx_q   <= insert ? idx_x : idx_x + 4'd1;
          if (insert || !bit_val) ones_q <= '0;
          else if (ones_x != '1)  ones_q <= ones_x + 1'b1;
          else                    ones_q <= ones_x;
          if (byte_start) begin
            if (pre_q != '0)              pre_q <= pre_q - 1'b1;
            else if (!in_valid && !tx_req) trl_q <= trl_q - 1'b1;
          end
        end
      end
    end
  end

  assign in_ready    = take;
  assign busy        = busy_q;
  assign emit_o      = tick_act && !stop_now;
  assign space_o     = space_now;
  assign stuff_ins_o = bit_start && insert;
  assign stuff_en_o  = stuff_q;
  assign ones_o      = ones_q;

endmodule

// File: rtl/afsk_modulator.sv
module afsk_modulator #(
  parameter int SAMPLE_RATE = 9600,
  parameter int BIT_RATE    = 1200,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_HZ    = 2200,
  parameter int PHASE_W     = 9,
  parameter int CNT_W       = 8,
  parameter int STUFF_RUN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             tx_req,
  input  logic [CNT_W-1:0] preamble_len,
  input  logic [CNT_W-1:0] trailer_len,
  input  logic [7:0]       in_data,
  input  logic             in_esc,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       sample,
  output logic             sample_valid,
  output logic             busy
);
  localparam int WAVE_LEN   = 2 ** PHASE_W;
  localparam int SPB        = SAMPLE_RATE / BIT_RATE;
  localparam int MARK_STEP  = afsk_pkg::tone_step(MARK_HZ, SAMPLE_RATE, WAVE_LEN);
  localparam int SPACE_STEP = afsk_pkg::tone_step(SPACE_HZ, SAMPLE_RATE, WAVE_LEN);
  localparam int ONES_W     = 4;

  logic               emit_w, space_w, stuff_ins_w, stuff_en_w;
  logic [ONES_W-1:0]  ones_w;
  logic [PHASE_W-1:0] phase_w;

  afsk_framer #(
    .SAMPLES_PER_BIT(SPB), .CNT_W(CNT_W), .STUFF_RUN(STUFF_RUN), .ONES_W(ONES_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .tx_req(tx_req),
    .preamble_len(preamble_len), .trailer_len(trailer_len),
    .in_data(in_data), .in_esc(in_esc), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .emit_o(emit_w), .space_o(space_w), .stuff_ins_o(stuff_ins_w),
    .stuff_en_o(stuff_en_w), .ones_o(ones_w)
  );

  afsk_dds #(
    .PHASE_W(PHASE_W), .MARK_STEP(MARK_STEP), .SPACE_STEP(SPACE_STEP)
  ) u_dds (
    .clk(clk), .rst_n(rst_n), .step_i(emit_w), .space_i(space_w),
    .phase_o(phase_w), .sample_o(sample), .valid_o(sample_valid)
  );

endmodule

// File: rtl/afsk_modulator_chk.sv
module afsk_modulator_chk #(
  parameter int PHASE_W    = 9,
  parameter int MARK_STEP  = 64,
  parameter int SPACE_STEP = 117,
  parameter int STUFF_RUN  = 5,
  parameter int ONES_W     = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sample_tick,
  input logic               in_valid,
  input logic               in_ready,
  input logic               sample_valid,
  input logic               busy,
  input logic [PHASE_W-1:0] phase,
  input logic               stuff_en,
  input logic [ONES_W-1:0]  ones
);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(phase));

  assert_valid_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> ($past(sample_tick) && $past(busy)));

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> ((phase == PHASE_W'($past(phase) + MARK_STEP)) ||
                      (phase == PHASE_W'($past(phase) + SPACE_STEP))));

  assert_stuff_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_en |-> (ones <= ONES_W'(STUFF_RUN)));

  assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sample_valid);

  assert_ready_in_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_valid && sample_tick && busy));

endmodule

bind afsk_modulator afsk_modulator_chk #(
  .PHASE_W(PHASE_W), .MARK_STEP(MARK_STEP), .SPACE_STEP(SPACE_STEP),
  .STUFF_RUN(STUFF_RUN), .ONES_W(ONES_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .in_valid(in_valid),
  .in_ready(in_ready), .sample_valid(sample_valid), .busy(busy),
  .phase(phase_w), .stuff_en(stuff_en_w), .ones(ones_w)
);

// File: tb/afsk_modulator_tb.sv
module afsk_modulator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic tx_req = 1'b0;
  logic [7:0] preamble_len = '0, trailer_len = '0, in_data = '0;
  logic in_esc = 1'b0, in_valid = 1'b0;
  logic in_ready, sample_valid, busy;
  logic [7:0] sample;

  afsk_modulator u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .tx_req(tx_req),
    .preamble_len(preamble_len), .trailer_len(trailer_len), .in_data(in_data),
    .in_esc(in_esc), .in_valid(in_valid), .in_ready(in_ready), .sample(sample),
    .sample_valid(sample_valid), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int exp_q[$];
  logic [7:0] src_d[$];
  logic       src_e[$];
  int model_phase = 0;
  bit model_space = 0;
  int seen = 0, first_pop = -1, cycles = 0;
  string tag = "R2";
  logic pop_pend = 1'b0, tick_seen = 1'b0;
  bit ticking = 0;
  int tick_cnt = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Reference sample per the requirement text
  function automatic int quarter(int h);
    return 128 + (127 * h * (256 - h) + 8192) / 16384;
  endfunction
  function automatic int expect_sample(int p);
    int h;
    h = p % 256;
    if (h >= 128) h = 255 - h;
    return (p >= 256) ? 255 - quarter(h) : quarter(h);
  endfunction

  task automatic model_bit(bit swap);
    if (swap) model_space = !model_space;
    for (int s = 0; s < 8; s++) begin
      model_phase = (model_phase + (model_space ? 117 : 64)) % 512;
      exp_q.push_back(expect_sample(model_phase));
    end
  endtask

  task automatic model_byte(int b, bit stuff);
    int run;
    run = 0;
    for (int i = 0; i < 8; i++) begin
      bit v;
      if (stuff && run >= 5) begin
        model_bit(1'b1);
        run = 0;
      end
      v = (b >> i) & 1;
      model_bit(!v);
      run = v ? run + 1 : 0;
    end
  endtask

  // Stimulus drivers at the falling edge
  always @(negedge clk) begin
    if (ticking) begin
      sample_tick <= (tick_cnt == 0);
      tick_cnt = (tick_cnt + 1) % TICK_DIV;
    end else begin
      sample_tick <= 1'b0;
    end
    if (pop_pend) begin
      void'(src_d.pop_front());
      void'(src_e.pop_front());
    end
    in_valid <= (src_d.size() > 0);
    in_data  <= (src_d.size() > 0) ? src_d[0] : 8'h00;
    in_esc   <= (src_e.size() > 0) ? src_e[0] : 1'b0;
  end

  always @(posedge clk) begin
    pop_pend  <= in_ready;
    tick_seen <= sample_tick;
    if (in_ready && first_pop < 0) first_pop = seen;
    cycles++;
    if (cycles > WATCHDOG) begin
      chk(0, "watchdog", cycles, WATCHDOG);
      finish_run();
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      seen++;
      chk(tick_seen, "R3 valid one cycle after tick", 0, 1);
      if (exp_q.size() == 0) begin
        chk(0, "R9 sample after expected end", sample, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(sample == e, tag, sample, e);
      end
    end
  end

  task automatic run_frame(int pre, int trl, string t);
    logic [7:0] d[$];
    logic       e[$];
    d = src_d; e = src_e;
    tag = t;
    model_space = 0;
    for (int i = 0; i < pre; i++) model_byte(8'h7E, 0);
    foreach (d[i]) model_byte(d[i], e[i] || !(d[i] == 8'h7E || d[i] == 8'h7F));
    for (int i = 0; i < trl; i++) model_byte(8'h7E, 0);
    seen = 0; first_pop = -1;
    @(negedge clk);
    preamble_len <= 8'(pre);
    trailer_len  <= 8'(trl);
    tx_req <= 1'b1;
    @(negedge clk);
    tx_req <= 1'b0;
    chk(busy == 1'b1, "R8 busy after request", busy, 1);
  endtask

  task automatic wait_idle(string t, int n_data, int pre);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {t, " R9 all expected samples seen"}, exp_q.size(), 0);
    chk(src_d.size() == 0, {t, " R11 all bytes consumed"}, src_d.size(), 0);
    if (n_data > 0)
      chk(first_pop == pre * 64, {t, " R8 first byte after preamble"}, first_pop, pre * 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sample == 8'd128, "R1 sample", sample, 128);
    chk(sample_valid == 1'b0, "R1 sample_valid", sample_valid, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    ticking = 1;
    repeat (20) @(negedge clk);
    chk(seen == 0, "R1 idle ticks silent", seen, 0);
    chk(sample == 8'd128, "R1 idle phase held", sample, 128);

    // Frame A: data with stuffing, raw and escaped framing values
    src_d = '{8'hA5, 8'hFF, 8'h7E, 8'h7E, 8'h7F, 8'h3E};
    src_e = '{1'b0,  1'b0,  1'b0,  1'b1,  1'b0,  1'b0};
    run_frame(2, 1, "R2 R4 R5 R6 R7 frameA sample");
    wait_idle("frameA", 6, 2);

    // Frame B: no data, preamble then trailer only
    run_frame(1, 2, "R3 R9 frameB sample");
    wait_idle("frameB", 0, 1);
    chk(seen == 3 * 64, "R9 frameB sample count", seen, 192);

    // Frame C: request while busy reloads the trailer
    model_space = 0;
    tag = "R10 frameC sample";
    model_byte(8'h7E, 0);
    for (int i = 0; i < 3; i++) model_byte(8'h7E, 0);
    seen = 0;
    preamble_len <= 8'd1;
    trailer_len  <= 8'd1;
    tx_req <= 1'b1;
    @(negedge clk);
    tx_req <= 1'b0;
    repeat (50) @(negedge clk);
    trailer_len <= 8'd3;
    tx_req <= 1'b1;
    @(negedge clk);
    tx_req <= 1'b0;
    wait_idle("frameC", 0, 1);
    chk(seen == 4 * 64, "R10 trailer reloaded", seen, 256);

    // Frame D: single escaped 0x7F then 0x00
    src_d = '{8'h7F, 8'h00};
    src_e = '{1'b1,  1'b0};
    run_frame(0, 0, "R6 R7 frameD sample");
    wait_idle("frameD", 2, 0);

    finish_run();
  end

endmodule